// File: doc/BRIEF.md
# Sensor Fault Detector and Mode Controller

This block watches one physical sensor against a model-based prediction of the same quantity. On each sample strobe it takes the magnitude of the gap between the measured and predicted values and compares it against a programmable limit. A run of out-of-limit samples confirms a fault. The block then moves from detection mode, where a light predictor only checks the sensor, to replacement mode, where a precise predictor stands in for the sensor. A run of in-limit samples, measured against the replacement prediction, returns the block to detection mode.

Every mode change raises a one-cycle request to the external reconfiguration logic. Samples are then ignored until that logic reports completion. The block also picks the value passed downstream: the live sensor reading in detection mode and the live prediction in replacement mode. It also registers the value fed back to the predictor for its next evaluation. Software can force the move into replacement mode for testing.

Top module: `sensor_fault_monitor`

## Requirements
- R1: After an accepted sample, `err_flag` is 1 exactly when the magnitude of (meas_val − pred_val) is strictly greater than `thresh`. Both values are read as two's-complement signed and the difference is exact, with no wrap. `thresh` is unsigned. A gap equal to `thresh` is not an error.
- R2: In detection mode (`fault_mode` = 0), `corr_val` equals `meas_val` combinationally and unchanged.
- R3: In detection mode, `persist_n` consecutive accepted out-of-limit samples switch the block to replacement mode, and `fault_mode` is 1 after the edge of the last of those samples. An accepted in-limit sample restarts the run. A `persist_n` of 0 acts as 1.
- R4: In replacement mode (`fault_mode` = 1), `corr_val` equals `pred_val` combinationally.
- R5: On each accepted sample, `fb_val` loads `meas_val` if the block was in detection mode at that edge, or `pred_val` if it was in replacement mode.
- R6: `force_sw` high at an edge, in detection mode and not waiting, switches the block to replacement mode at that edge. In replacement mode or while waiting, `force_sw` has no effect.
- R7: In replacement mode, `persist_n` consecutive accepted in-limit samples return the block to detection mode. An accepted out-of-limit sample restarts the run.
- R8: `reconf_req` is 1 for exactly the one cycle after each edge at which `fault_mode` changes, and is 0 at all other times.
- R9: After a mode change, samples leave `err_flag`, `fb_val` and the persistence run untouched until an edge that sees `reconf_done` = 1. Samples from the next edge onward are accepted again.
- R10: An edge with `smp_valid` = 0 changes neither `err_flag` nor `fb_val`.
- R11: Synchronous active-low reset gives detection mode, `err_flag` = 0, `reconf_req` = 0, `fb_val` = 0 and a cleared run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; meas_val and pred_val are valid |
| meas_val | input | DATA_W | Measured sensor value, signed |
| pred_val | input | DATA_W | Predicted value, signed |
| thresh | input | DATA_W | Unsigned deviation limit |
| persist_n | input | CNT_W | Consecutive-sample count for switching (0 acts as 1) |
| force_sw | input | 1 | Software command to enter replacement mode |
| reconf_done | input | 1 | Reconfiguration finished |
| err_flag | output | 1 | Last accepted sample was out of limit |
| fault_mode | output | 1 | 0 detection, 1 replacement |
| reconf_req | output | 1 | One-cycle reconfiguration request |
| corr_val | output | DATA_W | Value passed downstream |
| fb_val | output | DATA_W | Value latched for the next prediction |

## Verification
The bench sweeps signed value pairs across the full range under several limits. The pairs include gaps exactly at the limit and one above it, and the extreme pair whose difference needs an extra bit. A design that compares with `>=` or wraps the difference would flag the wrong samples. Persistence runs are broken by one good sample, to catch a counter that fails to restart, and a zero count is checked to catch a block that never switches. While waiting for reconfiguration, samples with fresh values are applied. A design that keeps comparing would move `fb_val` or `err_flag`, and one that does not release would never accept again. A force in replacement mode is applied to catch a spurious second request.

// File: rtl/sfm_pkg.sv
// Package: shared mode encoding for the sensor fault monitor.
// Assumes: one-bit mode, detection encoded as 0.
package sfm_pkg;
    typedef enum logic {
        MODE_DETECT  = 1'b0,
        MODE_REPLACE = 1'b1
    } sfm_mode_e;
endpackage

// File: rtl/sfm_dev_cmp.sv
// Module: sfm_dev_cmp
// Computes whether the exact magnitude of (a - b) exceeds a limit.
// Assumes: a and b are two's-complement signed, limit unsigned; purely combinational.
module sfm_dev_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    input  logic [DATA_W-1:0] limit,
    output logic              over
);
    localparam int EXT_W = DATA_W + 1;

    logic signed [EXT_W-1:0] diff;
    logic        [EXT_W-1:0] mag;

    // Sign-extend both operands so the difference cannot wrap, then compare magnitude.
    always_comb begin
        diff = $signed({a_val[DATA_W-1], a_val}) - $signed({b_val[DATA_W-1], b_val});
        mag  = diff[EXT_W-1] ? EXT_W'(-diff) : EXT_W'(diff);
        over = mag > {1'b0, limit};
    end

    // Equal inputs never count as a deviation.
    always_comb begin
        if (a_val == b_val) begin
            assert_equal_no_err_R1: assert (!over);
        end
    end
endmodule

// File: rtl/sfm_run_counter.sv
// Module: sfm_run_counter
// Counts consecutive qualifying steps and reports the step that completes a run.
// Assumes: limit 0 behaves as 1; clr has priority over counting.
module sfm_run_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             cond,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_eff;
    logic [CNT_W:0]   nxt;

    // Effective limit and completion detect.
    always_comb begin
        lim_eff = (limit == '0) ? CNT_W'(1) : limit;
        nxt     = {1'b0, cnt_q} + (CNT_W + 1)'(1);
        hit     = step && cond && (nxt >= {1'b0, lim_eff});
    end

    // Run length register: restart on clear, miss or completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            if (cond && !hit) cnt_q <= cnt_q + CNT_W'(1);
            else              cnt_q <= '0;
        end
    end

    assert_run_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (!cond || hit)) |=> (cnt_q == '0));
endmodule

// File: rtl/sfm_mode_ctrl.sv
// Module: sfm_mode_ctrl
// Holds the operating mode, issues the reconfiguration pulse and the busy window.
// Assumes: hit is only raised on accepted samples; reconf_done ends the busy window.
module sfm_mode_ctrl
    import sfm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      force_sw,
    input  logic      reconf_done,
    output sfm_mode_e mode,
    output logic      reconf_req,
    output logic      busy,
    output logic      go
);
    sfm_mode_e mode_q;
    logic      req_q;
    logic      busy_q;

    // A change happens on a completed run or a force from detection mode.
    always_comb begin
        go = !busy_q && (hit || (force_sw && mode_q == MODE_DETECT));
    end

    // Mode, request pulse and wait-for-done state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_DETECT;
            req_q  <= 1'b0;
            busy_q <= 1'b0;
        end else if (go) begin
            mode_q <= (mode_q == MODE_DETECT) ? MODE_REPLACE : MODE_DETECT;
            req_q  <= 1'b1;
            busy_q <= 1'b1;
        end else begin
            req_q <= 1'b0;
            if (busy_q && reconf_done) busy_q <= 1'b0;
        end
    end

    assign mode       = mode_q;
    assign reconf_req = req_q;
    assign busy       = busy_q;

    assert_req_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_req |=> !reconf_req);
    assert_change_requests_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> reconf_req);
    assert_req_only_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reconf_req |-> (mode_q != $past(mode_q)));
endmodule

// File: rtl/sensor_fault_monitor.sv
// Module: sensor_fault_monitor (top)
// Compares measured against predicted sensor values, confirms faults over a run
// of samples, switches between detection and replacement modes, and selects the
// downstream and feedback values.
// Assumes: synchronous active-low reset; samples accepted only on smp_valid
// outside the reconfiguration wait window.
module sensor_fault_monitor
    import sfm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] meas_val,
    input  logic [DATA_W-1:0] pred_val,
    input  logic [DATA_W-1:0] thresh,
    input  logic [CNT_W-1:0]  persist_n,
    input  logic              force_sw,
    input  logic              reconf_done,
    output logic              err_flag,
    output logic              fault_mode,
    output logic              reconf_req,
    output logic [DATA_W-1:0] corr_val,
    output logic [DATA_W-1:0] fb_val
);
    sfm_mode_e         mode;
    logic              busy;
    logic              go;
    logic              dev;
    logic              accept;
    logic              run_cond;
    logic              hit;
    logic              err_q;
    logic [DATA_W-1:0] fb_q;

    sfm_dev_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a_val (meas_val),
        .b_val (pred_val),
        .limit (thresh),
        .over  (dev)
    );

    // Sample qualification and the condition that extends the current run.
    always_comb begin
        accept   = smp_valid && !busy;
        run_cond = (mode == MODE_REPLACE) ? !dev : dev;
    end

    sfm_run_counter #(.CNT_W(CNT_W)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept),
        .cond  (run_cond),
        .clr   (go),
        .limit (persist_n),
        .hit   (hit)
    );

    sfm_mode_ctrl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .force_sw    (force_sw),
        .reconf_done (reconf_done),
        .mode        (mode),
        .reconf_req  (reconf_req),
        .busy        (busy),
        .go          (go)
    );

    // Error flag and predictor feedback register, updated on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            fb_q  <= '0;
        end else if (accept) begin
            err_q <= dev;
            fb_q  <= (mode == MODE_REPLACE) ? pred_val : meas_val;
        end
    end

    // Downstream value: sensor in detection mode, prediction in replacement mode.
    always_comb begin
        corr_val = (mode == MODE_REPLACE) ? pred_val : meas_val;
    end

    assign err_flag   = err_q;
    assign fb_val     = fb_q;
    assign fault_mode = (mode == MODE_REPLACE);

    assert_idle_holds_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(err_flag));
    assert_busy_holds_fb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fb_val));
    assert_fb_from_sensor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !fault_mode) |=> (fb_val == $past(meas_val)));
endmodule

// File: tb/sensor_fault_monitor_test.sv
module sensor_fault_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] meas_val = '0;
    logic [DW-1:0] pred_val = '0;
    logic [DW-1:0] thresh = '0;
    logic [CW-1:0] persist_n = '0;
    logic          force_sw = 1'b0;
    logic          reconf_done = 1'b0;
    logic          err_flag, fault_mode, reconf_req;
    logic [DW-1:0] corr_val, fb_val;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    sensor_fault_monitor #(.DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .meas_val(meas_val),
        .pred_val(pred_val), .thresh(thresh), .persist_n(persist_n),
        .force_sw(force_sw), .reconf_done(reconf_done), .err_flag(err_flag),
        .fault_mode(fault_mode), .reconf_req(reconf_req), .corr_val(corr_val),
        .fb_val(fb_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One edge with the given strobes; outputs are read 1 time unit after the edge.
    task automatic edge_with(input logic v, input int m, input int p,
                             input logic f, input logic d);
        smp_valid   = v;
        meas_val    = DW'(m);
        pred_val    = DW'(p);
        force_sw    = f;
        reconf_done = d;
        @(posedge clk);
        #1;
        smp_valid   = 1'b0;
        force_sw    = 1'b0;
        reconf_done = 1'b0;
    endtask

    function automatic int exp_err(input int m, input int p, input int t);
        int g;
        g = (m > p) ? (m - p) : (p - m);
        return (g > t) ? 1 : 0;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int t;
        int fb_hold;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11 fault_mode", fault_mode, 0);
        chk("R11 err_flag", err_flag, 0);
        chk("R11 reconf_req", reconf_req, 0);
        chk("R11 fb_val", fb_val, 0);
        rst_n = 1'b1;
        persist_n = 3'd7;

        // R1/R2/R5 sweep: each sample followed by an in-limit one so no run builds.
        for (int ti = 0; ti < 4; ti++) begin
            t = (ti == 0) ? 0 : (ti == 1) ? 10 : (ti == 2) ? 100 : 254;
            thresh = DW'(t);
            for (int m = -128; m < 128; m += 9) begin
                for (int p = -128; p < 128; p += 11) begin
                    edge_with(1'b1, m, p, 1'b0, 1'b0);
                    chk("R1 err sweep", err_flag, exp_err(m, p, t));
                    chk("R5 fb from sensor", fb_val, m & 8'hFF);
                    chk("R2 corr passthrough", corr_val, m & 8'hFF);
                    edge_with(1'b1, 0, 0, 1'b0, 1'b0);
                    chk("R1 clear sample", err_flag, 0);
                end
            end
        end
        // R1 boundaries: gap equal to limit, one above, and the widest pair.
        thresh = 8'd20;
        edge_with(1'b1, -10, 10, 1'b0, 1'b0);
        chk("R1 gap equal limit", err_flag, 0);
        edge_with(1'b1, 0, 0, 1'b0, 1'b0);
        edge_with(1'b1, -11, 10, 1'b0, 1'b0);
        chk("R1 gap above limit", err_flag, 1);
        edge_with(1'b1, 0, 0, 1'b0, 1'b0);
        thresh = 8'd254;
        edge_with(1'b1, -128, 127, 1'b0, 1'b0);
        chk("R1 widest gap", err_flag, 1);
        chk("R3 one miss no switch", fault_mode, 0);
        edge_with(1'b1, 0, 0, 1'b0, 1'b0);
        thresh = 8'd5;
        persist_n = 3'd3;

        // R10: invalid sample with a large gap changes nothing.
        edge_with(1'b1, 33, 33, 1'b0, 1'b0);
        edge_with(1'b0, 90, -90, 1'b0, 1'b0);
        chk("R10 err held", err_flag, 0);
        chk("R10 fb held", fb_val, 33);

        // R3: two misses, one good sample, then three misses.
        edge_with(1'b1, 50, 0, 1'b0, 1'b0);
        edge_with(1'b1, 50, 0, 1'b0, 1'b0);
        chk("R3 run of two", fault_mode, 0);
        edge_with(1'b1, 2, 0, 1'b0, 1'b0);
        edge_with(1'b1, 60, 0, 1'b0, 1'b0);
        edge_with(1'b1, 61, 0, 1'b0, 1'b0);
        chk("R3 restarted run", fault_mode, 0);
        edge_with(1'b1, 62, 0, 1'b0, 1'b0);
        chk("R3 switch after run", fault_mode, 1);
        chk("R8 request pulse", reconf_req, 1);
        chk("R5 fb on switching edge", fb_val, 62);

        // R9: samples ignored while waiting; R8 pulse ends.
        edge_with(1'b1, 7, 7, 1'b0, 1'b0);
        chk("R8 request ends", reconf_req, 0);
        chk("R9 err held busy", err_flag, 1);
        chk("R9 fb held busy", fb_val, 62);
        edge_with(1'b1, 9, 9, 1'b1, 1'b0);
        chk("R6 force ignored busy", reconf_req, 0);
        chk("R9 fb held busy 2", fb_val, 62);
        edge_with(1'b0, 0, 0, 1'b0, 1'b1);
        // R4: replacement value downstream.
        meas_val = 8'd100;
        pred_val = 8'd40;
        #1;
        chk("R4 corr is prediction", corr_val, 40);

        // R7: good, good, miss, then three good samples against the prediction.
        edge_with(1'b1, 41, 40, 1'b0, 1'b0);
        chk("R9 accepted after done", err_flag, 0);
        chk("R5 fb from prediction", fb_val, 40);
        edge_with(1'b1, 42, 44, 1'b0, 1'b0);
        edge_with(1'b1, 90, 45, 1'b0, 1'b0);
        chk("R7 miss in replacement", err_flag, 1);
        edge_with(1'b1, 46, 46, 1'b0, 1'b0);
        edge_with(1'b1, 47, 46, 1'b0, 1'b0);
        chk("R7 run of two", fault_mode, 1);
        edge_with(1'b1, 48, 47, 1'b0, 1'b0);
        chk("R7 return to detection", fault_mode, 0);
        chk("R8 request on return", reconf_req, 1);
        edge_with(1'b0, 0, 0, 1'b0, 1'b1);
        chk("R8 return pulse ends", reconf_req, 0);

        // R6: force from detection, then force in replacement has no effect.
        edge_with(1'b0, 0, 0, 1'b1, 1'b0);
        chk("R6 force switches", fault_mode, 1);
        chk("R6 force requests", reconf_req, 1);
        edge_with(1'b0, 0, 0, 1'b0, 1'b1);
        edge_with(1'b0, 0, 0, 1'b1, 1'b0);
        chk("R6 force in replacement", fault_mode, 1);
        chk("R6 no request in replacement", reconf_req, 0);
        edge_with(1'b1, 5, 5, 1'b0, 1'b0);
        edge_with(1'b1, 5, 5, 1'b0, 1'b0);
        edge_with(1'b1, 5, 5, 1'b0, 1'b0);
        chk("R7 recovered", fault_mode, 1 - 1);
        edge_with(1'b0, 0, 0, 1'b0, 1'b1);

        // R3: zero count acts as one.
        persist_n = 3'd0;
        edge_with(1'b1, 80, 0, 1'b0, 1'b0);
        chk("R3 zero count single miss", fault_mode, 1);
        fb_hold = fb_val;
        chk("R5 fb before zero run", fb_hold, 80);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule